// File: doc/BRIEF.md
# Handshaked Asynchronous Serial Transmitter

This block turns one byte into an asynchronous serial frame on a single output line. A frame consists of a low start bit, the eight data bits least-significant first, an odd parity bit and a high stop bit. Every bit lasts one baud period. The default baud period is 5208 cycles of a 100 MHz clock, which gives 19,200 baud.

A client starts a transfer by raising `send_req` with the byte on `tx_data`. The block copies the byte when the frame begins, so the bus may change afterwards. When the stop bit has finished, the block raises `send_ack`. It holds `send_ack` high for as long as `send_req` stays high. After `send_req` falls, it drops `send_ack` and waits for a fresh request. Inside the block are a baud-period timer that wraps on its last cycle, a bit-position counter, a control state machine and a registered line driver.

Top module: `uart_tx_hs`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it is sampled high, `ser_out` is 1 and `send_ack` is 0.
- R2: With no request pending and the block idle, `ser_out` stays 1.
- R3: The start bit is 0. The line falls on the second rising edge after the edge that samples `send_req` high in idle, and stays low for exactly one baud period (CLK_FREQ_HZ/BAUD_RATE cycles).
- R4: The data bits follow the start bit with bit 0 first and bit 7 last. Each holds for exactly one baud period.
- R5: After bit 7 comes one parity bit, lasting one baud period. Its value makes the eight data bits plus the parity bit hold an odd number of ones.
- R6: After the parity bit comes a stop bit of value 1, lasting one baud period. The line then stays 1.
- R7: `send_ack` is 0 during the frame. It rises on the edge where the stop bit ends, and it stays 1 with the line high for as long as `send_req` stays high. No second frame starts while `send_ack` is 1.
- R8: Once `send_req` is sampled low during acknowledge, `send_ack` falls two rising edges later. A new frame starts only on a new request.
- R9: The byte sent is the value on `tx_data` at the edge that starts the frame. Later changes of `tx_data` do not alter the frame.
- R10: The baud timer flags its last count, 5207 by default, and on that same cycle wraps to 0. It never counts past the last value.
- R11: The bit-position counter never exceeds 7 and advances only at the end of a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Transfer request, held high until acknowledged |
| tx_data | input | 8 | Byte to transmit |
| send_ack | output | 1 | Acknowledge that the frame has been sent (registered) |
| ser_out | output | 1 | Serial line, idle high (registered) |

## Verification
The bench builds the block with CLK_FREQ_HZ=4 and BAUD_RATE=1, so one baud period is four clock cycles. This small configuration makes it cheap to send all 256 byte values as frames. Every cycle of every frame is compared against a frame computed in the bench, so bit ordering, parity for every byte and exact bit lengths are all covered. The short period also keeps the tests that hold the acknowledge open, reset mid-frame and change the data bus in flight small enough to run many times.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_ACK
  } tx_state_e;

  typedef enum logic [2:0] {
    LINE_MARK, LINE_START, LINE_DATA, LINE_PARITY, LINE_STOP
  } line_sel_e;
endpackage

// File: rtl/baud_timer.sv
module baud_timer #(
  parameter int CYCLES = 5208
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (done)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> (cnt == '0));
  assert_range_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/bit_counter.sv
module bit_counter #(
  parameter int COUNT = 8,
  localparam int IW = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [IW-1:0] idx,
  output logic          last
);
  assign last = (idx == IW'(COUNT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (inc)   idx <= idx + 1'b1;
  end

  assert_idx_range_R11: assert property (@(posedge clk) disable iff (rst)
    idx <= IW'(COUNT - 1));
  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |-> !last);
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      send,
  input  logic      timer_done,
  input  logic      bit_last,
  output logic      timer_clr,
  output logic      bit_clr,
  output logic      bit_inc,
  output logic      load,
  output logic      ack,
  output line_sel_e line_sel
);
  tx_state_e state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  always_comb begin
    state_nx  = state;
    timer_clr = 1'b0;
    bit_clr   = 1'b0;
    bit_inc   = 1'b0;
    load      = 1'b0;
    ack       = 1'b0;
    line_sel  = LINE_MARK;
    unique case (state)
      ST_IDLE: begin
        timer_clr = 1'b1;
        bit_clr   = 1'b1;
        if (send) begin
          load     = 1'b1;
          state_nx = ST_START;
        end
      end
      ST_START: begin
        line_sel = LINE_START;
        if (timer_done) state_nx = ST_DATA;
      end
      ST_DATA: begin
        line_sel = LINE_DATA;
        if (timer_done) begin
          if (bit_last) state_nx = ST_PARITY;
          else          bit_inc  = 1'b1;
        end
      end
      ST_PARITY: begin
        line_sel = LINE_PARITY;
        if (timer_done) state_nx = ST_STOP;
      end
      ST_STOP: begin
        line_sel = LINE_STOP;
        if (timer_done) state_nx = ST_ACK;
      end
      ST_ACK: begin
        timer_clr = 1'b1;
        ack       = 1'b1;
        if (!send) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && send) |=> (state == ST_ACK));
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && !send) |=> (state == ST_IDLE));
endmodule

// File: rtl/tx_datapath.sv
module tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  line_sel_e         line_sel,
  input  logic [IW-1:0]     bit_idx,
  input  logic              ack_in,
  output logic              sout,
  output logic              sent
);
  logic [DATA_W-1:0] data_q;
  logic              parity;

  assign parity = ~^data_q;

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (load) data_q <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sout <= 1'b1;
      sent <= 1'b0;
    end else begin
      sent <= ack_in;
      unique case (line_sel)
        LINE_START:  sout <= 1'b0;
        LINE_DATA:   sout <= data_q[bit_idx];
        LINE_PARITY: sout <= parity;
        default:     sout <= 1'b1;
      endcase
    end
  end

  assert_mark_high_R2: assert property (@(posedge clk) disable iff (rst)
    (line_sel == LINE_MARK) |=> sout);
  assert_ack_line_high_R7: assert property (@(posedge clk) disable iff (rst)
    sent |-> sout);
  assert_data_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (line_sel != LINE_MARK) |=> $stable(data_q));
endmodule

// File: rtl/uart_tx_hs.sv
module uart_tx_hs
  import uart_tx_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int BAUD_RATE   = 19_200,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_req,
  input  logic [DATA_W-1:0] tx_data,
  output logic              send_ack,
  output logic              ser_out
);
  localparam int CYCLES_PER_BIT = CLK_FREQ_HZ / BAUD_RATE;
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic          timer_clr, timer_done;
  logic          bit_clr, bit_inc, bit_last;
  logic          load, ack;
  logic [IW-1:0] bit_idx;
  line_sel_e     line_sel;

  baud_timer #(.CYCLES(CYCLES_PER_BIT)) u_timer (
    .clk(clk), .rst(rst), .clr(timer_clr), .done(timer_done)
  );

  bit_counter #(.COUNT(DATA_W)) u_bits (
    .clk(clk), .rst(rst), .clr(bit_clr), .inc(bit_inc),
    .idx(bit_idx), .last(bit_last)
  );

  tx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .send(send_req), .timer_done(timer_done),
    .bit_last(bit_last), .timer_clr(timer_clr), .bit_clr(bit_clr),
    .bit_inc(bit_inc), .load(load), .ack(ack), .line_sel(line_sel)
  );

  tx_datapath #(.DATA_W(DATA_W), .IW(IW)) u_dp (
    .clk(clk), .rst(rst), .load(load), .din(tx_data),
    .line_sel(line_sel), .bit_idx(bit_idx), .ack_in(ack),
    .sout(ser_out), .sent(send_ack)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (ser_out && !send_ack));
endmodule

// File: tb/test_uart_tx_hs.sv
module test_uart_tx_hs;
  localparam int CPB = 4;
  localparam int NBITS = 11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       send_req = 1'b0;
  logic [7:0] tx_data = '0;
  logic       send_ack, ser_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_tx_hs #(.CLK_FREQ_HZ(4), .BAUD_RATE(1), .DATA_W(8)) i_uart_tx_hs (
    .clk(clk), .rst(rst), .send_req(send_req), .tx_data(tx_data),
    .send_ack(send_ack), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input int bi);
    if (bi == 0) return "R3";
    if (bi <= 8) return "R4";
    if (bi == 9) return "R5";
    return "R6";
  endfunction

  // Sends one frame, flips tx_data in flight, holds the request 'hold' extra cycles.
  task automatic run_frame(input logic [7:0] b, input int hold);
    logic [NBITS-1:0] fr;
    fr = {1'b1, ~^b, b, 1'b0};
    @(negedge clk);
    tx_data = b; send_req = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b1, "R3", ser_out, 1);
    tx_data = ~b; // R9: capture at frame start
    for (int c = 1; c <= NBITS * CPB; c++) begin
      int bi;
      @(negedge clk);
      bi = (c - 1) / CPB;
      check(ser_out == fr[bi], req_of(bi), ser_out, fr[bi]);
      if (c == NBITS * CPB) check(send_ack == 1'b0, "R7", send_ack, 0);
    end
    @(negedge clk);
    check(send_ack == 1'b1, "R7", send_ack, 1);
    check(ser_out == 1'b1, "R6", ser_out, 1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(send_ack == 1'b1 && ser_out == 1'b1, "R7", {send_ack, ser_out}, 3);
    end
    send_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(send_ack == 1'b0, "R8", send_ack, 0);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      check(ser_out == 1'b1 && send_ack == 1'b0, "R8", {send_ack, ser_out}, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ser_out == 1'b1, "R1", ser_out, 1);
    check(send_ack == 1'b0, "R1", send_ack, 0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(ser_out == 1'b1, "R2", ser_out, 1);
    end
    for (int v = 0; v < 256; v++) run_frame(8'(v), 0);
    run_frame(8'h47, 25);
    run_frame(8'h4F, 3);
    // Reset in the middle of a frame
    @(negedge clk);
    tx_data = 8'h00; send_req = 1'b1;
    repeat (10) @(negedge clk);
    send_req = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b1, "R1", ser_out, 1);
    check(send_ack == 1'b0, "R1", send_ack, 0);
    rst = 1'b0;
    for (int i = 0; i < 3 * CPB * NBITS; i++) begin
      @(negedge clk);
      check(ser_out == 1'b1, "R2", ser_out, 1);
    end
    run_frame(8'hA5, 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule